// File: doc/BRIEF.md
# HDLC Receive FCS Checker

This block sits behind an HDLC receiver that has already stripped flags and removed stuffed bits. It takes the resulting byte stream, one byte per valid strobe, with a marker on the first byte of each frame and a separate one-cycle strobe when the closing flag has been seen. It runs a frame check over every byte and, at the end of the frame, emits one status byte saying whether the checksum residue was correct and whether the frame was long enough to count as valid.

Three mode inputs, sampled with the first byte of a frame, shape the behaviour. The wide-check input switches from the 16-bit CCITT polynomial (two checksum bytes) to the 32-bit polynomial (four checksum bytes). The forward input passes the checksum bytes downstream as ordinary data, ahead of the status byte, while still checking them. The disable input stops the block from treating any bytes as checksum: all bytes pass through and the minimum valid length drops to one byte. With forwarding off and checking on, the output lags the input by the checksum length, so the checksum bytes are dropped inside the block.

Top module: `hdlc_fcs_check`

## Requirements
- R1: With the wide-check input low, the checksum is CRC-CCITT (reflected, bytes fed LSB first, preset all ones) over every byte of the frame; a frame whose last two bytes are the complemented CRC sent low byte first leaves residue 0xF0B8 and reports CRC-ok (status bit 0) as 1.
- R2: With the wide-check input high, the checksum is CRC-32 (reflected, preset all ones) over every byte; a frame ending in the four complemented CRC bytes, low byte first, leaves residue 0xDEBB20E3 and reports CRC-ok as 1.
- R3: With forwarding off and checking on, only the bytes before the last 2 (or 4) are output, in arrival order; the checksum bytes never appear on the output, and the first byte of a frame produces no output in the following cycle.
- R4: With forwarding on, every received byte, checksum included, is output in order one cycle after it arrives, and the CRC-ok bit still reflects the residue.
- R5: With checking disabled, every received byte is output one cycle after it arrives, CRC-ok reads 0, and a frame of one or more bytes is valid.
- R6: With checking on, a frame whose total byte count is not greater than the checksum length reports valid (status bit 1) as 0; a longer frame reports 1.
- R7: One cycle after the end strobe of an open frame, the block outputs a byte flagged by the status output, with bit 0 CRC-ok, bit 1 valid and bits 7..2 zero; it arrives in the cycle right after the last data byte output.
- R8: A frame with any byte corrupted reports CRC-ok as 0.
- R9: Bytes received outside a frame (no start marker since the last end strobe) and end strobes outside a frame produce no output.
- R10: Reset clears the outputs to zero and closes any open frame, so a later end strobe produces no status byte.
- R11: The mode inputs are taken with the first byte; changing them later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte strobe |
| inData | input | 8 | Input byte |
| frameStart | input | 1 | Marks the byte as the first of a frame |
| frameEnd | input | 1 | Closing flag seen (no byte in this cycle) |
| crc32Sel | input | 1 | Select the 32-bit checksum |
| fcsForward | input | 1 | Pass checksum bytes downstream as data |
| checkDisable | input | 1 | Treat no bytes as checksum |
| outValid | output | 1 | Output byte strobe |
| outData | output | 8 | Output data or status byte |
| outStatus | output | 1 | Output byte is the frame status |

## Verification
The assertions assume the receiver never raises the end strobe in the same cycle as a byte or a start marker, and that a start marker only comes with a valid byte. The bench drives each frame as a run of consecutive bytes followed immediately by a lone end strobe, then leaves idle cycles, so these assumptions always hold. Mode inputs are changed only between frames except in the one test that deliberately flips them mid-frame.

// File: rtl/hdlc_fcs_pkg.sv
package hdlc_fcs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [15:0] POLY16 = 16'h8408;
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [15:0] RES16 = 16'hF0B8;
  localparam logic [31:0] RES32 = 32'hDEBB20E3;
  localparam int ST_CRC_OK = 0;
  localparam int ST_VALID = 1;

  typedef struct packed {
    logic       crcInit;
    logic       crcStep;
    logic       push;
    logic       emitDirect;
    logic       emitHeld;
    logic       emitStatus;
    logic       wide;
    logic [2:0] holdDepth;
    logic       frameValid;
    logic       checkOn;
  } fcsStrobe_t;

  function automatic logic [15:0] crc16Step(input logic [15:0] c, input logic [BYTE_W-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY16) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] crc32Step(input logic [31:0] c, input logic [BYTE_W-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY32) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/hdlc_fcs_ctrl.sv
module hdlc_fcs_ctrl
  import hdlc_fcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       crc32Sel,
  input  logic       fcsForward,
  input  logic       checkDisable,
  output fcsStrobe_t strb
);
  localparam int PAD_W = CNT_W - 3;

  logic inFrame;
  logic wideQ, fwdQ, disQ;
  logic [CNT_W-1:0] byteCount;

  logic startByte, byteIn;
  logic wideEff, fwdEff, disEff;
  logic [2:0] fcsLen, holdDepth;
  logic [CNT_W-1:0] cntBefore;

  assign startByte = inValid && frameStart;
  assign byteIn    = inValid && (frameStart || inFrame);
  assign wideEff   = startByte ? crc32Sel     : wideQ;
  assign fwdEff    = startByte ? fcsForward   : fwdQ;
  assign disEff    = startByte ? checkDisable : disQ;
  assign fcsLen    = disEff ? 3'd0 : (wideEff ? 3'd4 : 3'd2);
  assign holdDepth = fwdEff ? 3'd0 : fcsLen;
  assign cntBefore = startByte ? '0 : byteCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      wideQ     <= 1'b0;
      fwdQ      <= 1'b0;
      disQ      <= 1'b0;
      byteCount <= '0;
    end else begin
      if (startByte) begin
        inFrame <= 1'b1;
        wideQ   <= crc32Sel;
        fwdQ    <= fcsForward;
        disQ    <= checkDisable;
      end else if (frameEnd) begin
        inFrame <= 1'b0;
      end
      if (byteIn && cntBefore != '1)
        byteCount <= cntBefore + 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.crcInit    = startByte;
    strb.crcStep    = byteIn;
    strb.push       = byteIn;
    strb.emitDirect = byteIn && (holdDepth == 3'd0);
    strb.emitHeld   = byteIn && (holdDepth != 3'd0) &&
                      (cntBefore >= {{PAD_W{1'b0}}, holdDepth});
    strb.emitStatus = frameEnd && inFrame && !startByte;
    strb.wide       = wideEff;
    strb.holdDepth  = holdDepth;
    strb.checkOn    = !disEff;
    strb.frameValid = disEff ? (byteCount != '0)
                             : (byteCount > {{PAD_W{1'b0}}, fcsLen});
  end
endmodule

// File: rtl/hdlc_fcs_datapath.sv
module hdlc_fcs_datapath
  import hdlc_fcs_pkg::*;
#(
  parameter int MAX_HOLD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  fcsStrobe_t        strb,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outStatus
);
  logic [BYTE_W-1:0] hold [MAX_HOLD];
  logic [15:0] crc16Q;
  logic [31:0] crc32Q;
  logic [BYTE_W-1:0] heldByte, statusByte;
  logic crcOk;

  for (genvar g = 0; g < MAX_HOLD; g++) begin : g_hold
    if (g == 0) begin : g_head
      always_ff @(posedge clk)
        if (strb.push) hold[g] <= inData;
    end else begin : g_tail
      always_ff @(posedge clk)
        if (strb.push) hold[g] <= hold[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crc16Q <= '1;
      crc32Q <= '1;
    end else if (strb.crcStep) begin
      crc16Q <= crc16Step(strb.crcInit ? 16'hFFFF : crc16Q, inData);
      crc32Q <= crc32Step(strb.crcInit ? 32'hFFFFFFFF : crc32Q, inData);
    end
  end

  assign heldByte = (strb.holdDepth == 3'd4) ? hold[3] : hold[1];
  assign crcOk    = strb.checkOn && (strb.wide ? (crc32Q == RES32) : (crc16Q == RES16));

  always_comb begin
    statusByte           = '0;
    statusByte[ST_CRC_OK] = crcOk;
    statusByte[ST_VALID]  = strb.frameValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outStatus <= 1'b0;
    end else begin
      outValid  <= strb.emitDirect || strb.emitHeld || strb.emitStatus;
      outStatus <= strb.emitStatus;
      if (strb.emitStatus)    outData <= statusByte;
      else if (strb.emitHeld) outData <= heldByte;
      else if (strb.emitDirect) outData <= inData;
    end
  end
endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check
  import hdlc_fcs_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MAX_HOLD = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       crc32Sel,
  input  logic       fcsForward,
  input  logic       checkDisable,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outStatus
);
  fcsStrobe_t strb;

  hdlc_fcs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .frameEnd(frameEnd), .crc32Sel(crc32Sel), .fcsForward(fcsForward),
    .checkDisable(checkDisable), .strb(strb)
  );

  hdlc_fcs_datapath #(.MAX_HOLD(MAX_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb),
    .outValid(outValid), .outData(outData), .outStatus(outStatus)
  );
endmodule

// File: rtl/hdlc_fcs_check_sva.sv
module hdlc_fcs_check_sva
  import hdlc_fcs_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       frameStart,
  input logic       frameEnd,
  input logic       fcsForward,
  input logic       checkDisable,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outStatus,
  input fcsStrobe_t strb
);
  a_r7_status_after_end: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitStatus |=> (outValid && outStatus));

  a_r7_status_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    outStatus |-> (outValid && outData[7:2] == 6'd0));

  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !frameEnd) |=> !outValid);

  a_r4_direct_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && frameStart && (fcsForward || checkDisable)) |=>
      (outValid && !outStatus && outData == $past(inData)));

  a_r3_first_byte_held: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && frameStart && !fcsForward && !checkDisable) |=> !outValid);
endmodule

bind hdlc_fcs_check hdlc_fcs_check_sva u_sva (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
  .frameStart(frameStart), .frameEnd(frameEnd), .fcsForward(fcsForward),
  .checkDisable(checkDisable), .outValid(outValid), .outData(outData),
  .outStatus(outStatus), .strb(strb)
);

// File: tb/hdlc_fcs_check_bench.sv
`timescale 1ns/1ps
module hdlc_fcs_check_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, frameStart = 1'b0, frameEnd = 1'b0;
  logic [7:0] inData = '0;
  logic crc32Sel = 1'b0, fcsForward = 1'b0, checkDisable = 1'b0;
  logic outValid, outStatus;
  logic [7:0] outData;

  int tests = 0, fails = 0;
  int cyc = 0;
  int capN = 0;
  logic [7:0] capData [32];
  logic       capStat [32];
  int         capCyc  [32];

  always #2.5 clk = ~clk;

  hdlc_fcs_check u_hdlc_fcs_check (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .frameStart(frameStart), .frameEnd(frameEnd), .crc32Sel(crc32Sel),
    .fcsForward(fcsForward), .checkDisable(checkDisable),
    .outValid(outValid), .outData(outData), .outStatus(outStatus)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (outValid && capN < 32) begin
      capData[capN] = outData;
      capStat[capN] = outStatus;
      capCyc[capN]  = cyc;
      capN = capN + 1;
    end
  end

  // {wide, fwd, dis, corrupt, len[3:0], expStatus{valid,crcOk}}
  localparam int NVEC = 11;
  localparam logic [NVEC-1:0][9:0] VEC = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 2'b11},  // R1 R3
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 2'b11},  // R2 R3
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 2'b11},  // R4
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 2'b11},  // R4
    {1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 2'b10},  // R8
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd7, 2'b10},  // R8
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 2'b10},  // R5
    {1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 2'b10},  // R5
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'b01},  // R6
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 2'b01},  // R6
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 2'b11}   // R6
  };

  function automatic logic [15:0] benchCrc16(input logic [7:0] b [16], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[k][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  function automatic logic [31:0] benchCrc32(input logic [7:0] b [16], input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[k][j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runFrame(input bit wide, input bit fwd, input bit dis, input bit corrupt,
                          input int len, input logic [1:0] expSt, input bit flipMid, input string req);
    logic [7:0] fb [16];
    logic [15:0] f16;
    logic [31:0] f32;
    int n, expN;
    for (int i = 0; i < 16; i++) fb[i] = 8'((i * 29) + (len * 7) + 3 + int'(wide));
    n = len;
    if (!dis) begin
      if (wide) begin
        f32 = ~benchCrc32(fb, len);
        for (int i = 0; i < 4; i++) fb[n + i] = f32[8*i +: 8];
        n = n + 4;
      end else begin
        f16 = ~benchCrc16(fb, len);
        fb[n] = f16[7:0];
        fb[n + 1] = f16[15:8];
        n = n + 2;
      end
    end
    if (corrupt) fb[0] = fb[0] ^ 8'h10;
    expN = (dis || fwd) ? n : len;

    @(negedge clk);
    capN = 0;
    crc32Sel = wide; fcsForward = fwd; checkDisable = dis;
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1; inData = fb[i]; frameStart = (i == 0);
      @(negedge clk);
      if (flipMid && i == 0) begin
        crc32Sel = ~wide; fcsForward = ~fwd; checkDisable = ~dis;
      end
    end
    inValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    repeat (3) @(negedge clk);

    check(capN == expN + 1, req, "output byte count", capN, expN + 1);
    if (capN == expN + 1) begin
      bit dataOk = 1'b1;
      for (int i = 0; i < expN; i++)
        if (capData[i] !== fb[i] || capStat[i] !== 1'b0) dataOk = 1'b0;
      check(dataOk, req, "data bytes in order", 0, 0);
      check(capStat[expN] === 1'b1 && capData[expN] === {6'd0, expSt}, "R7",
            {req, " status byte"}, int'(capData[expN]), int'({6'd0, expSt}));
      if (expN > 0)
        check(capCyc[expN] == capCyc[expN-1] + 1, "R7", "status right after last data",
              capCyc[expN], capCyc[expN-1] + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(outValid === 1'b0 && outStatus === 1'b0 && outData === 8'd0, "R10",
          "outputs in reset", int'({outValid, outStatus, outData}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] e = VEC[v];
      runFrame(e[9], e[8], e[7], e[6], int'(e[5:2]), e[1:0], 1'b0, $sformatf("vec%0d", v));
    end

    // R11: mode inputs flipped after the first byte do not affect the frame
    runFrame(1'b0, 1'b0, 1'b0, 1'b0, 5, 2'b11, 1'b1, "R11");
    runFrame(1'b1, 1'b1, 1'b0, 1'b0, 3, 2'b11, 1'b1, "R11");

    // R9: bytes and end strobe outside a frame
    @(negedge clk);
    capN = 0;
    crc32Sel = 1'b0; fcsForward = 1'b1; checkDisable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      inValid = 1'b1; inData = 8'(8'hA0 + i); frameStart = 1'b0;
      @(negedge clk);
    end
    inValid = 1'b0; frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    repeat (3) @(negedge clk);
    check(capN == 0, "R9", "output outside frame", capN, 0);

    // R10: reset closes an open frame
    inValid = 1'b1; inData = 8'h55; frameStart = 1'b1;
    @(negedge clk);
    inValid = 1'b0; frameStart = 1'b0; rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    capN = 0;
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    repeat (3) @(negedge clk);
    check(capN == 0, "R10", "no status after reset", capN, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule